// File: doc/BRIEF.md
# Register-Controlled SPI Flash Byte Shifter

This block is an SPI master for a serial flash that software operates through one 32-bit access word. The word carries three data bytes, a byte-count field, a start bit that is never stored, a chip-select bit and a ready flag. Writing the word with the start bit set shifts one, two or three of the data bytes out on the serial line, byte 0 first. The same number of bytes is captured from the flash, and each received byte replaces the transmitted byte in the slot it came from.

Software drives chip select directly, and a transfer never changes it. A flash command, its address and its payload can therefore be sent as several transfers while the select line stays low. Software polls the ready flag to find out when the received bytes can be read.

Top module: `spi_flash_xfer`

## Requirements
- R1: After reset the access word reads 0x10000000 (ready=1, all else 0), `spi_cs_n` is 1, and `spi_sclk` and `spi_mosi` are 0.
- R2: Data byte 0 sits at bits 7:0, byte 1 at 15:8, byte 2 at 23:16 and the count at 25:24. Each byte lane of a write is stored only where its `reg_be` bit is 1. The start bit (26) always reads 0.
- R3: A write with `reg_be[3]`=1 and bit 26=1 while ready clears ready (bit 28) on the next edge. Ready returns to 1 exactly 16·n·SCK_HALF cycles after that edge, where n is the number of bytes moved.
- R4: Bit 27 set to 1 drives `spi_cs_n` low, and set to 0 drives it high. It changes only on a write with `reg_be[3]`=1, and such a write takes effect even during a transfer. Starting or finishing a transfer never changes it.
- R5: Bytes go out in slot order (0, then 1, then 2), most significant bit first. `spi_mosi` changes only while `spi_sclk` is low or at its falling edge, and `spi_miso` is sampled at the rising edge. `spi_sclk` has a period of 2·SCK_HALF cycles.
- R6: When a transfer ends, every slot that was sent holds the byte received in that slot. Slots that were not sent keep their value.
- R7: Count 0 moves 1 byte, count 1 moves 2 bytes, and counts 2 and 3 both move 3 bytes. The count field reads back as written.
- R8: While ready is 0, a start request and any write to the data bytes or the count field are ignored.
- R9: While ready is 1, `spi_sclk` and `spi_mosi` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the access word |
| reg_be | input | 4 | Byte-lane enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current access word |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The access word can be read combinationally, so a write becomes visible at the first edge after it is applied. The bench drives inputs and samples outputs on falling clock edges, which puts that first edge between a write and the next sample. After each start, the bench counts falling edges until ready reads 1 and compares the count with 16·n·SCK_HALF, which confirms that ready is 0 in every earlier sample. Received bytes, untouched slots and chip select are read in the sample where ready first reads 1. The serial bit stream is captured by a flash model on the serial clock edges and compared after the transfer.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_SLOTS = 3;
  localparam int DATA_W    = BYTE_W * NUM_SLOTS;
  localparam int WORD_W    = 32;
  localparam int CNT_LO    = 24;
  localparam int CNT_W     = 2;
  localparam int GO_BIT    = 26;
  localparam int SEL_BIT   = 27;
  localparam int RDY_BIT   = 28;
  localparam int CTRL_LANE = 3;

  // last slot index moved by a count value; value 3 behaves as 2
  function automatic logic [CNT_W-1:0] last_slot(input logic [CNT_W-1:0] cnt);
    return (cnt > CNT_W'(NUM_SLOTS - 1)) ? CNT_W'(NUM_SLOTS - 1) : cnt;
  endfunction
endpackage

// File: rtl/sfx_sck_tick.sv
module sfx_sck_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfx_shift_eng.sv
module sfx_shift_eng
  import sfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  slot_last,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int BC_W = $clog2(DATA_W + 1);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic              rxb_q, rxb_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [BC_W-1:0]   nb_q, nb_d;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    rxb_d  = rxb_q;
    sh_d   = sh_q;
    bc_d   = bc_q;
    nb_d   = nb_q;
    done   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      sh_d   = tx_word;
      bc_d   = '0;
      nb_d   = BC_W'((int'(slot_last) + 1) * BYTE_W);
    end else if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rxb_d  = miso;
      end else begin
        sclk_d = 1'b0;
        sh_d   = {sh_q[DATA_W-2:0], rxb_q};
        bc_d   = bc_q + BC_W'(1);
        if (bc_q == nb_q - BC_W'(1)) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      rxb_q  <= 1'b0;
      sh_q   <= '0;
      bc_q   <= '0;
      nb_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      rxb_q  <= rxb_d;
      if (start || busy_q) begin
        sh_q <= sh_d;
        bc_q <= bc_d;
        nb_q <= nb_d;
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = busy_q & sh_q[DATA_W-1];
  assign rx_word = sh_d;
endmodule

// File: rtl/sfx_regs.sv
module sfx_regs
  import sfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output logic [WORD_W-1:0] rdata,
  output logic              sel,
  output logic              start,
  output logic [DATA_W-1:0] tx_word,
  output logic [CNT_W-1:0]  slot_last
);
  logic [DATA_W-1:0] data_q, data_d, data_w;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_w;
  logic              sel_q, sel_d;
  logic              ctrl_wr;
  logic [CNT_W-1:0]  run_last;

  assign ctrl_wr = wr_en && be[CTRL_LANE];
  assign start   = ctrl_wr && wdata[GO_BIT] && !busy;

  always_comb begin
    data_w = data_q;
    cnt_w  = cnt_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (wr_en && be[i] && !busy) data_w[i*BYTE_W +: BYTE_W] = wdata[i*BYTE_W +: BYTE_W];
    end
    if (ctrl_wr && !busy) cnt_w = wdata[CNT_LO +: CNT_W];
  end

  // slot 0 leaves first: place it at the top of the shift word
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      tx_word[(NUM_SLOTS-1-i)*BYTE_W +: BYTE_W] = data_w[i*BYTE_W +: BYTE_W];
    end
  end

  assign slot_last = last_slot(cnt_w);
  assign run_last  = last_slot(cnt_q);

  always_comb begin
    data_d = data_w;
    cnt_d  = cnt_w;
    sel_d  = ctrl_wr ? wdata[SEL_BIT] : sel_q;
    if (done) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (i <= int'(run_last))
          data_d[i*BYTE_W +: BYTE_W] = rx_word[(int'(run_last) - i)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (wr_en || done) begin
        data_q <= data_d;
        cnt_q  <= cnt_d;
      end
      if (ctrl_wr) sel_q <= sel_d;
    end
  end

  always_comb begin
    rdata                      = '0;
    rdata[DATA_W-1:0]          = data_q;
    rdata[CNT_LO +: CNT_W]     = cnt_q;
    rdata[SEL_BIT]             = sel_q;
    rdata[RDY_BIT]             = !busy;
  end

  assign sel = sel_q;
endmodule

// File: rtl/spi_flash_xfer.sv
module spi_flash_xfer
  import sfx_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic              busy, done, tick, sel, start;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic [CNT_W-1:0]  slot_last;

  sfx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .be(reg_be), .wdata(reg_wdata),
    .busy(busy), .done(done), .rx_word(rx_word), .rdata(reg_rdata), .sel(sel),
    .start(start), .tx_word(tx_word), .slot_last(slot_last)
  );

  sfx_sck_tick #(.HALF(SCK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  sfx_shift_eng u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_last(slot_last), .tx_word(tx_word),
    .tick(tick), .miso(spi_miso), .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi),
    .done(done), .rx_word(rx_word)
  );

  assign spi_cs_n = ~sel;
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi
);
  a_r3_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_be[3] && reg_wdata[26] && reg_rdata[28]) |=> !reg_rdata[28]);

  a_r4_select_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n != $past(spi_cs_n)) |-> $past(reg_wr_en && reg_be[3]));

  a_r5_mosi_held_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[28] && $past(!reg_rdata[28])) |-> $stable(reg_rdata[25:0]));

  a_r9_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[28] |-> (!spi_sclk && !spi_mosi));
endmodule

bind spi_flash_xfer sfx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_be(reg_be),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/spi_flash_xfer_tb_top.sv
module spi_flash_xfer_tb_top;
  localparam int HALF = 2;

  logic        clk, rst_n, reg_wr_en, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0;
  int fails  = 0;

  logic [23:0] resp_sh;
  logic [23:0] cap;
  int          nbits;

  spi_flash_xfer #(.SCK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // flash model: shifts on falling serial clock, captures on rising
  assign spi_miso = resp_sh[23];
  always @(negedge spi_sclk) resp_sh = resp_sh << 1;
  always @(posedge spi_sclk) begin
    cap   = {cap[22:0], spi_mosi};
    nbits = nbits + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  function automatic logic [23:0] slot_order(input logic [23:0] d);
    return {d[7:0], d[15:8], d[23:16]};
  endfunction

  task automatic prime(input logic [23:0] resp);
    resp_sh = slot_order(resp);
    cap     = '0;
    nbits   = 0;
  endtask

  task automatic xfer_check(input logic [23:0] d, input logic [1:0] cnt, input logic sel, input logic [23:0] resp);
    int nb, k;
    logic [23:0] exp_d;
    nb = (cnt == 2'd3) ? 3 : int'(cnt) + 1;
    prime(resp);
    wr(4'hF, {3'b000, 1'b0, sel, 1'b1, cnt, d});
    chk(reg_rdata[28] == 1'b0, "R3 ready low after start", 32'(reg_rdata[28]), 0);
    k = 0;
    while (!reg_rdata[28] && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(k == 16 * nb * HALF, "R3/R7 transfer length", k, 16 * nb * HALF);
    exp_d = d;
    for (int i = 0; i < nb; i++) exp_d[i*8 +: 8] = resp[i*8 +: 8];
    chk(reg_rdata[23:0] == exp_d, "R6 received bytes in place", reg_rdata[23:0], exp_d);
    chk(reg_rdata[25:24] == cnt, "R7 count readback", reg_rdata[25:24], cnt);
    chk(cap == (slot_order(d) >> (24 - 8 * nb)) && nbits == 8 * nb, "R5 serial order",
        cap, slot_order(d) >> (24 - 8 * nb));
    chk(spi_cs_n == !sel, "R4 select kept across transfer", spi_cs_n, !sel);
    chk(!spi_sclk && !spi_mosi, "R9 idle lines low", {spi_sclk, spi_mosi}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int k;
    logic [23:0] d0, r0;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_be = '0; reg_wdata = '0;
    prime(24'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(reg_rdata == 32'h1000_0000, "R1 reset word", reg_rdata, 32'h1000_0000);
    chk(spi_cs_n == 1'b1, "R1 select high", spi_cs_n, 1);
    chk(!spi_sclk && !spi_mosi, "R1 lines low", {spi_sclk, spi_mosi}, 0);

    // R2 byte lanes and start bit readback
    wr(4'hF, 32'h0011_2233);
    wr(4'b0010, 32'hFFFF_A5FF);
    chk(reg_rdata[23:0] == 24'h11A533, "R2 lane write", reg_rdata[23:0], 24'h11A533);
    wr(4'b1000, {3'b000, 1'b0, 1'b1, 1'b0, 2'd3, 24'hFFFFFF});
    chk(reg_rdata == 32'h1B11_A533, "R2 control lane only", reg_rdata, 32'h1B11_A533);
    chk(spi_cs_n == 1'b0, "R4 select low on write", spi_cs_n, 0);
    wr(4'b1000, 32'h0000_0000);
    chk(spi_cs_n == 1'b1, "R4 select high on write", spi_cs_n, 1);

    // sweep of counts and patterns
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        d0 = 24'(32'h3C96A5 * (p + 1) + c * 32'h010203);
        r0 = ~d0 ^ 24'(p * 32'h111111);
        xfer_check(d0, 2'(c), p[0], r0);
      end
    end

    // R8: writes while busy
    d0 = 24'hC0FFEE; r0 = 24'h5A6B7C;
    prime(r0);
    wr(4'hF, {3'b000, 1'b0, 1'b1, 1'b1, 2'd0, d0});
    k = 0;
    while (!reg_rdata[28] && k < 2000) begin
      @(negedge clk);
      k++;
      if (k == 3) begin
        reg_wr_en = 1'b1; reg_be = 4'hF;
        reg_wdata = {3'b000, 1'b0, 1'b0, 1'b1, 2'd2, 24'h123456};
      end else if (k == 4) begin
        reg_wr_en = 1'b0; reg_be = '0; reg_wdata = '0;
        chk(spi_cs_n == 1'b1, "R4 select write accepted while busy", spi_cs_n, 1);
      end
    end
    chk(k == 16 * HALF, "R8 busy start ignored length", k, 16 * HALF);
    chk(reg_rdata[23:0] == {d0[23:8], r0[7:0]}, "R8 busy data write ignored",
        reg_rdata[23:0], {d0[23:8], r0[7:0]});
    chk(reg_rdata[25:24] == 2'd0, "R8 busy count write ignored", reg_rdata[25:24], 0);
    repeat (40) @(negedge clk);
    chk(reg_rdata[28] && nbits == 8, "R8 no second transfer", nbits, 8);
    chk(reg_rdata[26] == 1'b0, "R2 start bit reads zero", reg_rdata[26], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule